// File: doc/BRIEF.md
# Time-of-Day Alarm Comparator with Repeat Masks

This block is the alarm section of a real-time clock. Software programs four
alarm bytes (seconds, minutes, hours, day of month), each holding a BCD value
with a repeat mask in bit 7. The current time of day arrives on four BCD input
buses from a timekeeping block outside this unit. A one-cycle `tick` marks each
new second. On every tick the unit compares the alarm against the current time
and, on a match, pulses `irq` for one clock cycle.

The mask bits choose how often the alarm repeats. With no masks the alarm fires
once a month. Masking the day gives once a day. Masking the day and the hour
gives once an hour. Masking the day, the hour and the minute gives once a
minute. Any other mask pattern fires on every tick. Writes carrying an
out-of-range BCD value are dropped, so the stored alarm is always a legal time.

Top module: `alarm_unit`

## Requirements
- R1: Register index 0 is seconds, 1 is minutes, 2 is hours and 3 is day of month. An accepted write stores the whole byte, mask bit included. `reg_rdata` always shows the stored byte at `reg_addr`, without delay.
- R2: A seconds or minutes write is accepted only when bits 3:0 are at most 9 and bits 6:4 are at most 5, which is the BCD range 0 to 59. A rejected write leaves the register unchanged.
- R3: An hours write is accepted only when bits 3:0 are at most 9 and the BCD value in bits 5:0 is 0 to 23. A rejected write leaves the register unchanged.
- R4: A day write is accepted only when bits 3:0 are at most 9 and bits 5:0 are not zero. A rejected write leaves the register unchanged.
- R5: When no bit 7 is set in any of the four registers, a tick matches only when seconds[6:0], minutes[6:0], hours[5:0] and day[5:0] all equal the same bits of the time inputs (monthly repeat).
- R6: When only the day register's bit 7 is set, the day is ignored and seconds, minutes and hours must match (daily repeat).
- R7: When only the day and hours bit 7 are set, seconds and minutes must match (hourly repeat).
- R8: When only the day, hours and minutes bit 7 are set, seconds must match (repeat each minute).
- R9: Every other mask pattern makes every tick a match (repeat each second).
- R10: `irq` is high for the single cycle after a tick that matched. It is low in every other cycle, including every cycle that does not follow a tick.
- R11: A tick in the same cycle as a register write is compared against the contents the register held before that write.
- R12: A synchronous active-low reset clears all four registers and drives `irq` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register index (0 sec, 1 min, 2 hour, 3 day) |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Stored byte at `reg_addr` |
| tick | input | 1 | One-cycle strobe at each new second |
| now_sec | input | 8 | Current seconds, BCD |
| now_min | input | 8 | Current minutes, BCD |
| now_hour | input | 8 | Current hours, BCD |
| now_date | input | 8 | Current day of month, BCD |
| irq | output | 1 | One-cycle alarm pulse |

## Verification
A register write and a second tick can arrive in the same cycle. The alarm
compare must then use the register contents from before the write. The bench
sets up this case on purpose: it programs an alarm that equals the current time,
then rewrites the seconds byte to a different value in the tick cycle, and it
expects an `irq` pulse on that tick and no pulse on the next tick at the same
time. The same overlap also occurs many times in the randomized phase. There the
behavioural model evaluates the match before it applies the write and compares
`irq` and `reg_rdata` on every clock.

// File: rtl/alarm_pkg.sv
// Package: shared constants, field indices and BCD helpers for the alarm unit.
// Assumes four alarm fields of one byte each, mask bit in the top bit.
package alarm_pkg;
    localparam int FIELDS   = 4;
    localparam int BYTE_W   = 8;
    localparam int ADDR_W   = $clog2(FIELDS);
    localparam int MASK_BIT = BYTE_W - 1;

    typedef enum logic [ADDR_W-1:0] {
        FLD_SEC  = 2'd0,
        FLD_MIN  = 2'd1,
        FLD_HOUR = 2'd2,
        FLD_DATE = 2'd3
    } field_e;

    typedef enum logic [2:0] {
        RPT_MONTH,
        RPT_DAY,
        RPT_HOUR,
        RPT_MINUTE,
        RPT_SECOND
    } repeat_e;

    typedef logic [FIELDS-1:0][BYTE_W-1:0] field_vec_t;

    // Bits that take part in the compare for a field.
    function automatic logic [BYTE_W-1:0] cmp_bits(input int idx);
        return (idx == FLD_SEC || idx == FLD_MIN) ? 8'h7F : 8'h3F;
    endfunction

    // Accept rule for a write into field idx.
    function automatic logic write_ok(input int idx, input logic [BYTE_W-1:0] d);
        logic units_ok;
        units_ok = (d[3:0] <= 4'd9);
        case (idx)
            FLD_SEC, FLD_MIN: return units_ok && (d[6:4] <= 3'd5);
            FLD_HOUR:         return units_ok && ((d[5:4] < 2'd2) ||
                                                  (d[5:4] == 2'd2 && d[3:0] <= 4'd3));
            default:          return units_ok && (d[5:0] != 6'd0);
        endcase
    endfunction
endpackage

// File: rtl/alarm_regfile.sv
// Module: alarm_regfile
// Holds the alarm bytes and drops writes whose BCD value is out of range.
// Assumes a single write port; there are no side effects on read.
module alarm_regfile
    import alarm_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [ADDR_W-1:0]    wr_addr,
    input  logic [BYTE_W-1:0]    wr_data,
    output field_vec_t           regs_q
);
    for (genvar g = 0; g < FIELDS; g++) begin : g_field
        logic accept;
        // Decide whether this field takes the current write.
        always_comb accept = wr_en && (wr_addr == ADDR_W'(g)) && write_ok(g, wr_data);

        // Store an accepted write; clear on reset.
        always_ff @(posedge clk) begin
            if (!rst_n)      regs_q[g] <= '0;
            else if (accept) regs_q[g] <= wr_data;
        end
    end
endmodule

// File: rtl/alarm_match.sv
// Module: alarm_match
// Combinational compare of alarm against current time with the repeat mode
// decoded from the mask bits. Assumes both sides are BCD in matching layout.
module alarm_match
    import alarm_pkg::*;
(
    input  field_vec_t alarm,
    input  field_vec_t now,
    output repeat_e    mode,
    output logic       hit
);
    logic [FIELDS-1:0] eq;
    logic [FIELDS-1:0] masks;

    for (genvar g = 0; g < FIELDS; g++) begin : g_cmp
        // Per-field equality over the meaningful BCD bits.
        always_comb begin
            eq[g]    = ((alarm[g] ^ now[g]) & cmp_bits(g)) == '0;
            masks[g] = alarm[g][MASK_BIT];
        end
    end

    // Decode the repeat rate from the mask pattern {date,hour,min,sec}.
    always_comb begin
        case (masks)
            4'b0000: mode = RPT_MONTH;
            4'b1000: mode = RPT_DAY;
            4'b1100: mode = RPT_HOUR;
            4'b1110: mode = RPT_MINUTE;
            default: mode = RPT_SECOND;
        endcase
    end

    // Select which field equalities must hold for the chosen rate.
    always_comb begin
        case (mode)
            RPT_MONTH:  hit = &eq;
            RPT_DAY:    hit = eq[FLD_SEC] && eq[FLD_MIN] && eq[FLD_HOUR];
            RPT_HOUR:   hit = eq[FLD_SEC] && eq[FLD_MIN];
            RPT_MINUTE: hit = eq[FLD_SEC];
            default:    hit = 1'b1;
        endcase
    end
endmodule

// File: rtl/alarm_unit.sv
// Module: alarm_unit (top)
// Alarm registers plus compare; a tick that matches gives one irq cycle.
// Assumes tick is a single-cycle strobe and the time inputs are stable with it.
module alarm_unit
    import alarm_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 reg_we,
    input  logic [ADDR_W-1:0]    reg_addr,
    input  logic [BYTE_W-1:0]    reg_wdata,
    output logic [BYTE_W-1:0]    reg_rdata,
    input  logic                 tick,
    input  logic [BYTE_W-1:0]    now_sec,
    input  logic [BYTE_W-1:0]    now_min,
    input  logic [BYTE_W-1:0]    now_hour,
    input  logic [BYTE_W-1:0]    now_date,
    output logic                 irq
);
    field_vec_t regs_q;
    field_vec_t now_vec;
    repeat_e    mode;
    logic       hit;
    logic       irq_q;

    alarm_regfile u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (reg_we),
        .wr_addr (reg_addr),
        .wr_data (reg_wdata),
        .regs_q  (regs_q)
    );

    // Gather the time inputs into field order.
    always_comb begin
        now_vec[FLD_SEC]  = now_sec;
        now_vec[FLD_MIN]  = now_min;
        now_vec[FLD_HOUR] = now_hour;
        now_vec[FLD_DATE] = now_date;
    end

    alarm_match u_match (
        .alarm (regs_q),
        .now   (now_vec),
        .mode  (mode),
        .hit   (hit)
    );

    // Register the match so irq is a clean single-cycle pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) irq_q <= 1'b0;
        else        irq_q <= tick && hit;
    end

    // Outputs: pulse and direct read of the addressed register.
    always_comb begin
        irq       = irq_q;
        reg_rdata = regs_q[reg_addr];
    end
endmodule

// File: rtl/alarm_unit_chk.sv
// Module: alarm_unit_chk
// Property checker attached to alarm_unit; observes ports and stored bytes.
module alarm_unit_chk
    import alarm_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              reg_we,
    input logic [ADDR_W-1:0] reg_addr,
    input logic [BYTE_W-1:0] reg_wdata,
    input logic              tick,
    input logic              irq,
    input field_vec_t        regs
);
    assert_reset_clears_R12: assert property (@(posedge clk)
        !rst_n |=> (regs == '0 && !irq));

    assert_irq_needs_tick_R10: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> $past(tick));

    assert_sec_mask_fires_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && regs[FLD_SEC][MASK_BIT]) |=> irq);

    assert_bad_sec_kept_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && reg_addr == FLD_SEC && reg_wdata[3:0] > 4'd9) |=> $stable(regs[FLD_SEC]));

    assert_bad_hour_kept_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && reg_addr == FLD_HOUR && reg_wdata[5:4] == 2'd3) |=> $stable(regs[FLD_HOUR]));

    assert_zero_date_kept_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && reg_addr == FLD_DATE && reg_wdata[5:0] == 6'd0) |=> $stable(regs[FLD_DATE]));

    assert_good_min_stored_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && reg_addr == FLD_MIN && reg_wdata[3:0] <= 4'd9 && reg_wdata[6:4] <= 3'd5)
        |=> regs[FLD_MIN] == $past(reg_wdata));
endmodule

bind alarm_unit alarm_unit_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_we    (reg_we),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .tick      (tick),
    .irq       (irq),
    .regs      (regs_q)
);

// File: tb/tb_alarm_unit.sv
// Bench for alarm_unit: directed cases, then random traffic, against a
// behavioural model that is compared on every clock at the falling edge.
module tb_alarm_unit;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_we = 1'b0;
    logic [1:0] reg_addr = 2'd0;
    logic [7:0] reg_wdata = 8'd0;
    logic [7:0] reg_rdata;
    logic       tick = 1'b0;
    logic [7:0] now_sec = 8'd0, now_min = 8'd0, now_hour = 8'd0, now_date = 8'd1;
    logic       irq;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    int    m_reg [4] = '{0, 0, 0, 0};
    bit    m_irq = 1'b0;
    string irq_tag = "R12";
    string rd_tag [4] = '{"R12", "R12", "R12", "R12"};

    always #10 clk = ~clk;

    alarm_unit dut (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .tick(tick),
        .now_sec(now_sec), .now_min(now_min), .now_hour(now_hour),
        .now_date(now_date), .irq(irq)
    );

    function automatic bit legal(int idx, int v);
        int u, t;
        u = v & 15;
        if (u > 9) return 0;
        if (idx <= 1) begin t = (v >> 4) & 7; return (t * 10 + u) <= 59; end
        t = (v >> 4) & 3;
        if (idx == 2) return (t * 10 + u) <= 23;
        return (t * 10 + u) != 0;
    endfunction

    function automatic bit same(int idx, int a, int b);
        int w;
        w = (idx <= 1) ? 127 : 63;
        return (a & w) == (b & w);
    endfunction

    task automatic compare();
        checks++;
        if (irq !== m_irq) begin
            failures++;
            $display("FAIL %s irq actual=%0b expected=%0b", irq_tag, irq, m_irq);
        end
        checks++;
        if (reg_rdata !== 8'(m_reg[reg_addr])) begin
            failures++;
            $display("FAIL %s rdata[%0d] actual=%02h expected=%02h",
                     rd_tag[reg_addr], reg_addr, reg_rdata, m_reg[reg_addr]);
        end
    endtask

    // One cycle: check the last result, drive new inputs, advance the model.
    task automatic step(bit rst, bit we, int a, int d, bit tk, int s, int mi, int h, int dt);
        int t [4];
        bit s_m, m_m, h_m, d_m, hit;
        @(negedge clk);
        compare();
        rst_n = !rst; reg_we = we; reg_addr = 2'(a); reg_wdata = 8'(d);
        tick = tk; now_sec = 8'(s); now_min = 8'(mi); now_hour = 8'(h); now_date = 8'(dt);
        t[0] = s; t[1] = mi; t[2] = h; t[3] = dt;
        if (rst) begin
            m_irq = 0; irq_tag = "R12";
            for (int i = 0; i < 4; i++) begin m_reg[i] = 0; rd_tag[i] = "R12"; end
            return;
        end
        // Match uses the contents before any write in this cycle (R11).
        s_m = m_reg[0][7]; m_m = m_reg[1][7]; h_m = m_reg[2][7]; d_m = m_reg[3][7];
        if (!s_m && !m_m && !h_m && !d_m) begin
            hit = same(0, m_reg[0], s) && same(1, m_reg[1], mi) && same(2, m_reg[2], h) && same(3, m_reg[3], dt);
            irq_tag = "R5";
        end else if (!s_m && !m_m && !h_m && d_m) begin
            hit = same(0, m_reg[0], s) && same(1, m_reg[1], mi) && same(2, m_reg[2], h);
            irq_tag = "R6";
        end else if (!s_m && !m_m && h_m && d_m) begin
            hit = same(0, m_reg[0], s) && same(1, m_reg[1], mi);
            irq_tag = "R7";
        end else if (!s_m && m_m && h_m && d_m) begin
            hit = same(0, m_reg[0], s);
            irq_tag = "R8";
        end else begin
            hit = 1; irq_tag = "R9";
        end
        if (!tk) irq_tag = "R10";
        else if (we) irq_tag = "R11";
        m_irq = tk && hit;
        if (we) begin
            if (legal(a, d)) begin m_reg[a] = d; rd_tag[a] = "R1"; end
            else rd_tag[a] = (a <= 1) ? "R2" : (a == 2) ? "R3" : "R4";
        end
    endtask

    task automatic wr(int a, int d);
        step(0, 1, a, d, 0, 0, 0, 0, 1);
    endtask

    task automatic rd(int a);
        step(0, 0, a, 0, 0, 0, 0, 0, 1);
    endtask

    task automatic tk(int s, int mi, int h, int dt);
        step(0, 0, 0, 0, 1, s, mi, h, dt);
    endtask

    initial begin
        int ws, wm, wh, wd, a, d;
        // R12: reset state
        step(1, 0, 0, 0, 0, 0, 0, 0, 1);
        step(1, 0, 0, 0, 0, 0, 0, 0, 1);
        rd(0); rd(3);
        // R1: program and read back all four fields
        wr(0, 'h30); wr(1, 'h15); wr(2, 'h08); wr(3, 'h12);
        rd(0); rd(1); rd(2); rd(3);
        // R2: rejected seconds/minutes values
        wr(0, 'h60); rd(0); wr(0, 'h1A); rd(0); wr(1, 'h75); rd(1);
        // R3: rejected hours values
        wr(2, 'h24); rd(2); wr(2, 'h1C); rd(2);
        // R4: rejected day values, including mask bit with zero day
        wr(3, 'h00); rd(3); wr(3, 'h80); rd(3); wr(3, 'h4A); rd(3);
        // R5: monthly match and mismatch on day only
        tk('h30, 'h15, 'h08, 'h12); rd(0); tk('h30, 'h15, 'h08, 'h13); rd(0);
        // R6: daily repeat ignores the day
        wr(3, 'h92); tk('h30, 'h15, 'h08, 'h27); rd(0); tk('h30, 'h15, 'h09, 'h12); rd(0);
        // R7: hourly repeat
        wr(2, 'h88); tk('h30, 'h15, 'h17, 'h05); rd(0); tk('h30, 'h16, 'h08, 'h12); rd(0);
        // R8: repeat each minute
        wr(1, 'h95); tk('h30, 'h44, 'h17, 'h05); rd(0); tk('h31, 'h15, 'h08, 'h12); rd(0);
        // R9: seconds mask and an unlisted pattern both fire every tick
        wr(0, 'hB0); tk('h01, 'h02, 'h03, 'h04); rd(0);
        wr(0, 'h30); wr(2, 'h08); wr(3, 'h12); wr(1, 'h95);
        tk('h59, 'h59, 'h23, 'h31); rd(0);
        // R10: no tick, no pulse; back-to-back ticks give back-to-back pulses
        step(0, 0, 0, 0, 0, 'h59, 'h59, 'h23, 'h31); tk('h00, 'h00, 'h00, 'h01); tk('h00, 'h00, 'h00, 'h01); rd(0);
        // R11: write in the tick cycle, compare uses old contents
        wr(1, 'h15);
        step(0, 1, 0, 'h31, 1, 'h30, 'h15, 'h08, 'h12); rd(0);
        tk('h30, 'h15, 'h08, 'h12); rd(0);
        // R12: reset in mid-run
        step(1, 0, 0, 0, 1, 0, 0, 0, 1); rd(1); rd(2);
        // Random traffic against the model
        for (int n = 0; n < 4000; n++) begin
            a = $urandom_range(0, 3);
            d = $urandom_range(0, 255);
            if ($urandom_range(0, 1) == 0) d = (d & 'h80) | (m_reg[a] & 'h7F);
            ws = ($urandom_range(0, 1) == 1) ? m_reg[0] : $urandom_range(0, 'h59);
            wm = ($urandom_range(0, 1) == 1) ? m_reg[1] : $urandom_range(0, 'h59);
            wh = ($urandom_range(0, 1) == 1) ? m_reg[2] : $urandom_range(0, 'h23);
            wd = ($urandom_range(0, 1) == 1) ? m_reg[3] : $urandom_range(1, 'h31);
            step($urandom_range(0, 199) == 0, $urandom_range(0, 2) == 0, a, d,
                 $urandom_range(0, 1) == 1, ws, wm, wh, wd);
        end
        rd(0);
        @(negedge clk);
        compare();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired before completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule